// File: doc/BRIEF.md
# Clock-Synchronous Byte Serial Port

This block moves fixed-size frames (eight bits by default) between a host and a peer over three wires: a serial clock, a transmit line and a receive line. A host loads a byte, selects master or slave operation and the clock polarity, and pulses a start strobe. In master mode the port produces the serial clock itself by dividing the system clock. In slave mode it follows a clock driven by the peer, brought into the system clock domain through a short synchronizer chain.

Each bit occupies one full serial clock period. The first clock edge of a bit period (the edge leaving the rest level) drives the next transmit bit. The second edge samples the receive line. Bits travel least significant first. The clock polarity input sets the rest level of the clock, and so decides which physical edge drives and which samples. When the last bit has been sampled, the port raises a one-cycle completion pulse together with the received byte. Between frames the transmit line keeps its final bit and the master clock rests at its idle level.

Top module: `sync_serial_port`

## Requirements
- R1: A frame carries exactly FRAME_BITS bits. Transmit bit k (bit 0 first) is on `txd` when the k-th sampling edge arrives. A master frame shows exactly 2*FRAME_BITS clock transitions.
- R2: Received bits are assembled least significant first: the bit sampled at the first sampling edge lands in `rx_byte[0]`.
- R3: With `cfg_pol`=1 the clock rests high. `txd` changes after falling edges and `rxd` is sampled on rising edges.
- R4: With `cfg_pol`=0 the clock rests low. `txd` changes after rising edges and `rxd` is sampled on falling edges.
- R5: After a frame ends, `txd` keeps the last bit sent until the next start.
- R6: In master mode the serial clock period is `clk_div` system cycles with bit 0 of `clk_div` ignored, so each half period is `clk_div[DIV_W-1:1]` cycles. A `clk_div` below 2 acts as 2.
- R7: In slave mode `sck_in` passes through SYNC_STAGES flops before its edges are detected. The frame is clocked only by those edges.
- R8: `done` is high for exactly one cycle per frame. `rx_byte` takes the received value in that same cycle and holds it until the next frame completes.
- R9: A `start` pulse while a frame is in progress is ignored, including any change of `tx_byte`.
- R10: After reset `done`=0, `rx_byte`=0, `txd`=0 and `sck_out`=1.
- R11: `sck_oe` is 1 in master mode and 0 in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = generate the serial clock, 0 = follow `sck_in` |
| cfg_pol | input | 1 | Clock rest level: 1 high, 0 low |
| clk_div | input | DIV_W | Master clock divisor (even, at least 2) |
| tx_byte | input | FRAME_BITS | Data to send, captured at start |
| start | input | 1 | One-cycle strobe that begins a frame |
| sck_in | input | 1 | Serial clock from the peer in slave mode |
| sck_out | output | 1 | Serial clock generated in master mode |
| sck_oe | output | 1 | Drive enable for the serial clock pin |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| rx_byte | output | FRAME_BITS | Last received frame |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
The bench builds the port with FRAME_BITS=8, SYNC_STAGES=2 and a narrow DIV_W=4. The narrow divisor field brings the fastest divisor (2), a zero divisor and an odd divisor within a short table of vectors. It also keeps every master frame only a few dozen cycles long. Two synchronizer stages give the shortest slave latency, and the bench runs the peer clock at four and five system cycles per half period. That exercises the tightest margin between a detected edge and the next bit.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   // one-cycle edge events seen by the shift engine
   typedef struct packed {
      logic lead;    // edge leaving the rest level: drive next bit
      logic trail;   // edge returning to the rest level: sample input
   } ssp_edge_t;

   localparam ssp_edge_t SSP_NO_EDGE = '{lead: 1'b0, trail: 1'b0};
endpackage

// File: rtl/ssp_mclk.sv
module ssp_mclk
   import ssp_pkg::*;
#(
   parameter int FRAME_BITS = 8,
   parameter int DIV_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             pol,
   input  logic [DIV_W-1:0] div,
   output logic             sck,
   output ssp_edge_t        ev
);
   localparam int TOGS  = 2 * FRAME_BITS;
   localparam int TOG_W = $clog2(TOGS + 1);
   localparam int HW    = DIV_W - 1;

   logic [HW-1:0]    half;
   logic [HW-1:0]    cnt;
   logic [TOG_W-1:0] tog;

   always_comb begin
      half = div[DIV_W-1:1];
      if (half == '0) half = HW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         tog <= '0;
         sck <= 1'b1;
         ev  <= SSP_NO_EDGE;
      end else begin
         ev <= SSP_NO_EDGE;
         if (!run) begin
            cnt <= '0;
            tog <= '0;
            sck <= pol;
         end else if (tog != TOG_W'(TOGS)) begin
            if (cnt == half - HW'(1)) begin
               cnt      <= '0;
               sck      <= ~sck;
               tog      <= tog + TOG_W'(1);
               ev.lead  <= ~tog[0];
               ev.trail <= tog[0];
            end else begin
               cnt <= cnt + HW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/ssp_sedge.sv
module ssp_sedge
   import ssp_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sck_in,
   input  logic      pol,
   output ssp_edge_t ev
);
   logic [SYNC_STAGES-1:0] sy;
   logic                   prev;
   logic                   rise, fall;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sy[0] <= 1'b0;
            else        sy[0] <= sck_in;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sy[i] <= 1'b0;
            else        sy[i] <= sy[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b0;
      else        prev <= sy[SYNC_STAGES-1];

   assign rise     = sy[SYNC_STAGES-1] & ~prev;
   assign fall     = ~sy[SYNC_STAGES-1] & prev;
   assign ev.lead  = pol ? fall : rise;
   assign ev.trail = pol ? rise : fall;
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift
   import ssp_pkg::*;
#(
   parameter int FRAME_BITS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [FRAME_BITS-1:0] tx_byte,
   input  ssp_edge_t             ev,
   input  logic                  rxd,
   output logic                  txd,
   output logic [FRAME_BITS-1:0] rx_byte,
   output logic                  done,
   output logic                  active
);
   localparam int CW = $clog2(FRAME_BITS);

   logic [FRAME_BITS-1:0] tx_sr, rx_sr, rx_next;
   logic [CW-1:0]         bitcnt;

   assign rx_next = {rxd, rx_sr[FRAME_BITS-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr   <= '0;
         rx_sr   <= '0;
         rx_byte <= '0;
         bitcnt  <= '0;
         txd     <= 1'b0;
         done    <= 1'b0;
         active  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (start) begin
               tx_sr  <= tx_byte;
               txd    <= tx_byte[0];
               bitcnt <= '0;
               active <= 1'b1;
            end
         end else begin
            if (ev.lead) txd <= tx_sr[0];
            if (ev.trail) begin
               tx_sr <= tx_sr >> 1;
               rx_sr <= rx_next;
               if (bitcnt == CW'(FRAME_BITS - 1)) begin
                  active  <= 1'b0;
                  done    <= 1'b1;
                  rx_byte <= rx_next;
               end else begin
                  bitcnt <= bitcnt + CW'(1);
               end
            end
         end
      end
   end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
   import ssp_pkg::*;
#(
   parameter int FRAME_BITS  = 8,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_master,
   input  logic                  cfg_pol,
   input  logic [DIV_W-1:0]      clk_div,
   input  logic [FRAME_BITS-1:0] tx_byte,
   input  logic                  start,
   input  logic                  sck_in,
   output logic                  sck_out,
   output logic                  sck_oe,
   input  logic                  rxd,
   output logic                  txd,
   output logic [FRAME_BITS-1:0] rx_byte,
   output logic                  done
);
   if (FRAME_BITS < 2) begin : g_bad_frame
      $error("FRAME_BITS must be at least 2");
   end
   if (DIV_W < 2) begin : g_bad_div
      $error("DIV_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   ssp_edge_t m_ev, s_ev, edge_sel;
   logic      frame_act;
   logic      edge_lead, edge_trail;

   ssp_mclk #(.FRAME_BITS(FRAME_BITS), .DIV_W(DIV_W)) u_mclk (
      .clk(clk), .rst_n(rst_n), .run(frame_act & cfg_master),
      .pol(cfg_pol), .div(clk_div), .sck(sck_out), .ev(m_ev));

   ssp_sedge #(.SYNC_STAGES(SYNC_STAGES)) u_sedge (
      .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .pol(cfg_pol), .ev(s_ev));

   assign edge_sel   = cfg_master ? m_ev : s_ev;
   assign edge_lead  = edge_sel.lead;
   assign edge_trail = edge_sel.trail;
   assign sck_oe     = cfg_master;

   ssp_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte),
      .ev(edge_sel), .rxd(rxd), .txd(txd), .rx_byte(rx_byte),
      .done(done), .active(frame_act));
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
   input logic clk,
   input logic rst_n,
   input logic master,
   input logic pol,
   input logic start,
   input logic sck_out,
   input logic txd,
   input logic done,
   input logic frame_act,
   input logic lead,
   input logic trail
);
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_closes_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!frame_act && $past(frame_act)));

   p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (master && $past(rst_n) && !frame_act && $past(!frame_act) && $stable(pol))
      |-> (sck_out == pol));

   p_txd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_act && !start) |=> $stable(txd));

   p_edge_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lead, trail}));

   p_no_edge_effect_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_act && start) |=> (frame_act || done));
endmodule

bind sync_serial_port ssp_checker chk (
   .clk(clk), .rst_n(rst_n), .master(cfg_master), .pol(cfg_pol),
   .start(start), .sck_out(sck_out), .txd(txd), .done(done),
   .frame_act(frame_act), .lead(edge_lead), .trail(edge_trail));

// File: tb/sync_serial_port_test.sv
`timescale 1ns/1ps
module sync_serial_port_test;
   localparam int DW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_master = 1'b1, cfg_pol = 1'b1;
   logic [DW-1:0] clk_div = DW'(2);
   logic [7:0]    tx_byte = '0;
   logic          start = 1'b0, sck_in = 1'b1, rxd = 1'b0;
   logic          sck_out, sck_oe, txd, done;
   logic [7:0]    rx_byte;

   int total = 0, bad = 0, done_hits = 0, dbl = 0;
   logic [7:0] got_rx = '0;
   logic done_prev = 1'b0;
   bit   finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   sync_serial_port #(.FRAME_BITS(8), .DIV_W(DW), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_pol(cfg_pol),
      .clk_div(clk_div), .tx_byte(tx_byte), .start(start), .sck_in(sck_in),
      .sck_out(sck_out), .sck_oe(sck_oe), .rxd(rxd), .txd(txd),
      .rx_byte(rx_byte), .done(done));

   // fields: master, pol, divisor / peer half period, tx, rx
   localparam int NV = 6;
   localparam logic [25:0] VEC [NV] = '{
      {1'b1, 1'b1, 8'd2, 8'hA5, 8'h3C},
      {1'b1, 1'b0, 8'd4, 8'h5A, 8'hC3},
      {1'b1, 1'b1, 8'd0, 8'hFF, 8'h00},
      {1'b1, 1'b0, 8'd5, 8'h01, 8'h80},
      {1'b0, 1'b1, 8'd4, 8'h96, 8'h69},
      {1'b0, 1'b0, 8'd5, 8'h0F, 8'hF0}
   };

   always @(negedge clk) begin
      if (rst_n && done) begin
         done_hits++;
         if (done_prev) dbl++;
         got_rx = rx_byte;
      end
      done_prev = done;
   end

   task automatic step;
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", what, act, exp);
      end
   endtask

   task automatic m_frame(input bit pol, input logic [7:0] div, input logic [7:0] tx,
                          input logic [7:0] rx, input bit mid_start);
      int k = 0, edges = 0, t = 0, lead_t0 = -1, per = -1, d0, eff;
      logic [7:0] gtx = '0;
      logic prev;
      string pt = pol ? "R3" : "R4";
      eff = (div < 2) ? 2 : int'(div & 8'hFE);
      cfg_master = 1'b1; cfg_pol = pol; clk_div = div[DW-1:0]; tx_byte = tx;
      repeat (3) step;
      chk(sck_out == pol, {pt, " idle level before frame"}, sck_out, pol);
      chk(sck_oe == 1'b1, "R11 master drives clock", sck_oe, 1);
      d0 = done_hits; prev = sck_out;
      start = 1'b1; step; start = 1'b0;
      while (done_hits == d0 && t < 3000) begin
         step; t++;
         start = 1'b0;
         if (sck_out != prev) begin
            edges++;
            if (sck_out != pol) begin
               if (k < 8) rxd = rx[k];
               if (lead_t0 < 0) lead_t0 = t;
               else if (per < 0) per = t - lead_t0;
               if (mid_start && k == 3) begin start = 1'b1; tx_byte = ~tx; end
            end else begin
               if (k < 8) gtx[k] = txd;
               k++;
            end
            prev = sck_out;
         end
      end
      chk(edges == 16 && k == 8, "R1 transitions per frame", edges, 16);
      chk(gtx == tx, {"R1 ", pt, " bits on txd at sampling edge"}, gtx, tx);
      if (mid_start) chk(gtx == tx, "R9 start during frame ignored", gtx, tx);
      chk(got_rx == rx, "R2 received byte lsb first", got_rx, rx);
      chk(per == eff, "R6 master clock period", per, eff);
      repeat (10) step;
      chk(sck_out == pol, {pt, " idle level after frame"}, sck_out, pol);
      chk(txd == tx[7], "R5 txd holds last bit", txd, tx[7]);
      chk(rx_byte == rx, "R8 rx_byte held", rx_byte, rx);
      chk(done_hits == d0 + 1, "R8 one done per frame", done_hits - d0, 1);
   endtask

   task automatic s_frame(input bit pol, input int hp, input logic [7:0] tx,
                          input logic [7:0] rx);
      int d0, w = 0;
      logic [7:0] gtx = '0;
      string pt = pol ? "R3" : "R4";
      cfg_master = 1'b0; cfg_pol = pol; sck_in = pol; tx_byte = tx;
      repeat (6) step;
      chk(sck_oe == 1'b0, "R11 slave releases clock", sck_oe, 0);
      d0 = done_hits;
      start = 1'b1; step; start = 1'b0;
      for (int k = 0; k < 8; k++) begin
         repeat (hp) step;
         sck_in = ~pol; rxd = rx[k];
         repeat (hp) step;
         gtx[k] = txd;
         sck_in = pol;
      end
      while (done_hits == d0 && w < 20) begin step; w++; end
      chk(gtx == tx, {"R7 ", pt, " slave transmit bits"}, gtx, tx);
      chk(got_rx == rx, "R7 R2 slave received byte", got_rx, rx);
      repeat (8) step;
      chk(txd == tx[7], "R5 slave txd holds last bit", txd, tx[7]);
      chk(done_hits == d0 + 1, "R8 slave one done", done_hits - d0, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired act=1 exp=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) step;
      // reset state, R10
      chk(done == 1'b0, "R10 done after reset", done, 0);
      chk(rx_byte == 8'h00, "R10 rx_byte after reset", rx_byte, 0);
      chk(txd == 1'b0, "R10 txd after reset", txd, 0);
      chk(sck_out == 1'b1, "R10 clock after reset", sck_out, 1);
      rst_n = 1'b1;
      repeat (2) step;

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][25])
            m_frame(VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], 1'b0);
         else
            s_frame(VEC[i][24], int'(VEC[i][23:16]), VEC[i][15:8], VEC[i][7:0]);
      end

      // directed: start strobe in mid frame, R9
      m_frame(1'b1, 8'd4, 8'hC6, 8'h5B, 1'b1);
      m_frame(1'b0, 8'd2, 8'h80, 8'h01, 1'b1);

      chk(dbl == 0, "R8 done never two cycles", dbl, 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule